// File: doc/BRIEF.md
# Vertical Countdown Divider with Field-Rate Windows

This block derives the vertical deflection pulse of a television timing chain from a stream of line strobes and a separated vertical sync strobe. A line counter restarts at every vertical pulse. A sync strobe produces a vertical pulse only when the counter lies inside an acceptance window. Outside the window the strobe is ignored. If no sync is accepted by the end of the window, the block inserts a pulse of its own there, so the output keeps running like a flywheel.

Three windows exist: one around the 50 Hz field length, one around the 60 Hz field length, and a wide search window used when no standard is known. The window is chosen by a two-bit field mode, a line-lock flag and a detector. The detector declares a standard after three consecutive fields whose accepted sync fell in the same standard's range. A separate override forces the search window, so that after a channel change the divider picks up the new signal at once.

Top module: `vert_countdown`

## Requirements
- R1: Under reset `vpulse_out`, `std_valid_out` and `rate_50_out` are all 0.
- R2: The line count is the number of `line_pulse` strobes since the last vertical pulse. A `vsync_in` strobe while the count lies inside the active window makes `vpulse_out` high for exactly one cycle, starting on the next clock edge, and the count restarts at 0.
- R3: A `vsync_in` strobe while the count lies outside the active window has no effect on `vpulse_out` or on the count.
- R4: If a `line_pulse` arrives while the count is at or above the window's upper bound and no sync is accepted in that cycle, a vertical pulse is inserted (flywheel) and the count restarts at 0.
- R5: Window bounds, inclusive: 50 Hz window 306..318, 60 Hz window 256..268, search window 240..330.
- R6: `search_force` = 1 selects the search window whatever the field mode.
- R7: Field mode 2'b00 (auto, 60 Hz fallback): with `line_locked` = 1 the window of the detected standard is used, or the search window if none is detected. With `line_locked` = 0 the 60 Hz window is used.
- R8: Field mode 2'b11 (auto, 50 Hz fallback) behaves as 2'b00, except that with `line_locked` = 0 the 50 Hz window is used.
- R9: Field mode 2'b01 forces the 60 Hz window. The change takes effect at once: if the count already exceeds 268, the next `line_pulse` fires a vertical pulse.
- R10: Field mode 2'b10 uses the window of the last detected standard (search window if none is detected) and freezes the detector, so `std_valid_out` and `rate_50_out` do not change.
- R11: The detector sets `std_valid_out` = 1 after three consecutive fields ended by an accepted sync whose count fell in the same standard's range. It then sets `rate_50_out` to 1 for 50 Hz and 0 for 60 Hz. A field ended by flywheel, or by an accepted sync outside both ranges, restarts the run. `std_valid_out` stays 1 until reset.
- R12: When `vsync_in` and `line_pulse` come in the same cycle while the count equals the window's upper bound, exactly one vertical pulse results, and it counts as an accepted sync for detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pulse | input | 1 | One-cycle strobe per video line |
| vsync_in | input | 1 | One-cycle separated vertical sync strobe |
| line_locked | input | 1 | High while the line oscillator is in lock |
| field_mode | input | 2 | 00 auto/60 fallback, 01 forced 60, 10 hold, 11 auto/50 fallback |
| search_force | input | 1 | Forces the wide search window |
| vpulse_out | output | 1 | One-cycle vertical pulse, registered |
| rate_50_out | output | 1 | Detected standard: 1 = 50 Hz, 0 = 60 Hz |
| std_valid_out | output | 1 | A standard has been detected |

## Verification
Two functions can fall in the same cycle: the flywheel insertion at the window's upper edge and the acceptance of a real sync. The bench provokes this by driving both strobes together, in forced 60 Hz mode, when exactly 268 lines have been counted since reset or since the last pulse. It judges the result in three ways: only one pulse appears, the following field counts from zero, and three such coincident fields make the detector declare 60 Hz. That last point proves the coincidence was taken as a sync and not as a flywheel.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    WIN_60   = 2'd0,
    WIN_50   = 2'd1,
    WIN_SRCH = 2'd2
  } win_e;

  localparam logic [1:0] MODE_AUTO60  = 2'b00;
  localparam logic [1:0] MODE_FORCE60 = 2'b01;
  localparam logic [1:0] MODE_HOLD    = 2'b10;
  localparam logic [1:0] MODE_AUTO50  = 2'b11;
endpackage

// File: rtl/vc_window_sel.sv
module vc_window_sel
  import vc_pkg::*;
#(
  parameter int CW     = 10,
  parameter int W50_LO = 306,
  parameter int W50_HI = 318,
  parameter int W60_LO = 256,
  parameter int W60_HI = 268,
  parameter int WS_LO  = 240,
  parameter int WS_HI  = 330
) (
  input  logic [1:0]    field_mode,
  input  logic          line_locked,
  input  logic          search_force,
  input  logic          det_valid,
  input  logic          det_50,
  output logic [CW-1:0] win_lo,
  output logic [CW-1:0] win_hi
);
  win_e win;
  win_e det_win;

  assign det_win = det_valid ? (det_50 ? WIN_50 : WIN_60) : WIN_SRCH;

  always_comb begin
    if (search_force) begin
      win = WIN_SRCH;
    end else begin
      case (field_mode)
        MODE_FORCE60: win = WIN_60;
        MODE_HOLD:    win = det_win;
        MODE_AUTO50:  win = line_locked ? det_win : WIN_50;
        default:      win = line_locked ? det_win : WIN_60;
      endcase
    end
  end

  always_comb begin
    case (win)
      WIN_50: begin
        win_lo = CW'(W50_LO);
        win_hi = CW'(W50_HI);
      end
      WIN_60: begin
        win_lo = CW'(W60_LO);
        win_hi = CW'(W60_HI);
      end
      default: begin
        win_lo = CW'(WS_LO);
        win_hi = CW'(WS_HI);
      end
    endcase
  end
endmodule

// File: rtl/vc_line_counter.sv
module vc_line_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_pulse,
  input  logic          vsync_in,
  input  logic [CW-1:0] win_lo,
  input  logic [CW-1:0] win_hi,
  output logic [CW-1:0] cnt,
  output logic          accept,
  output logic          flywheel,
  output logic          vpulse
);
  logic in_win;
  logic fire;

  assign in_win   = (cnt >= win_lo) && (cnt <= win_hi);
  assign accept   = vsync_in && in_win;
  assign flywheel = line_pulse && (cnt >= win_hi) && !accept;
  assign fire     = accept || flywheel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      vpulse <= 1'b0;
    end else begin
      vpulse <= fire;
      if (fire) begin
        cnt <= '0;
      end else if (line_pulse) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vc_std_detect.sv
module vc_std_detect #(
  parameter int CW     = 10,
  parameter int W50_LO = 306,
  parameter int W50_HI = 318,
  parameter int W60_LO = 256,
  parameter int W60_HI = 268,
  parameter int RUN    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          flywheel,
  input  logic [CW-1:0] cnt,
  input  logic          freeze,
  output logic          det_valid,
  output logic          det_50
);
  localparam int RW = $clog2(RUN + 1);
  localparam logic [RW-1:0] RUN_C  = RW'(RUN);
  localparam logic [RW-1:0] LAST_C = RW'(RUN - 1);

  logic          in50;
  logic          in60;
  logic          cand50;
  logic [RW-1:0] streak;

  assign in50 = (cnt >= CW'(W50_LO)) && (cnt <= CW'(W50_HI));
  assign in60 = (cnt >= CW'(W60_LO)) && (cnt <= CW'(W60_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      streak    <= '0;
      cand50    <= 1'b0;
      det_valid <= 1'b0;
      det_50    <= 1'b0;
    end else if (!freeze) begin
      if (accept && (in50 || in60)) begin
        if ((streak != '0) && (cand50 == in50)) begin
          if (streak < RUN_C) begin
            streak <= streak + 1'b1;
          end
          if (streak == LAST_C) begin
            det_valid <= 1'b1;
            det_50    <= cand50;
          end
        end else begin
          cand50 <= in50;
          streak <= RW'(1);
        end
      end else if (accept || flywheel) begin
        streak <= '0;
      end
    end
  end
endmodule

// File: rtl/vert_countdown.sv
module vert_countdown
  import vc_pkg::*;
#(
  parameter int CW     = 10,
  parameter int W50_LO = 306,
  parameter int W50_HI = 318,
  parameter int W60_LO = 256,
  parameter int W60_HI = 268,
  parameter int WS_LO  = 240,
  parameter int WS_HI  = 330,
  parameter int RUN    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_pulse,
  input  logic       vsync_in,
  input  logic       line_locked,
  input  logic [1:0] field_mode,
  input  logic       search_force,
  output logic       vpulse_out,
  output logic       rate_50_out,
  output logic       std_valid_out
);
  logic [CW-1:0] win_lo;
  logic [CW-1:0] win_hi;
  logic [CW-1:0] cnt_q;
  logic          accept;
  logic          flywheel;
  logic          det_valid;
  logic          det_50;

  vc_window_sel #(
    .CW(CW), .W50_LO(W50_LO), .W50_HI(W50_HI),
    .W60_LO(W60_LO), .W60_HI(W60_HI), .WS_LO(WS_LO), .WS_HI(WS_HI)
  ) i_win (
    .field_mode  (field_mode),
    .line_locked (line_locked),
    .search_force(search_force),
    .det_valid   (det_valid),
    .det_50      (det_50),
    .win_lo      (win_lo),
    .win_hi      (win_hi)
  );

  vc_line_counter #(.CW(CW)) i_cnt (
    .clk       (clk),
    .rst       (rst),
    .line_pulse(line_pulse),
    .vsync_in  (vsync_in),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .cnt       (cnt_q),
    .accept    (accept),
    .flywheel  (flywheel),
    .vpulse    (vpulse_out)
  );

  vc_std_detect #(
    .CW(CW), .W50_LO(W50_LO), .W50_HI(W50_HI),
    .W60_LO(W60_LO), .W60_HI(W60_HI), .RUN(RUN)
  ) i_det (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .flywheel (flywheel),
    .cnt      (cnt_q),
    .freeze   (field_mode == MODE_HOLD),
    .det_valid(det_valid),
    .det_50   (det_50)
  );

  assign rate_50_out   = det_50;
  assign std_valid_out = det_valid;
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int CW    = 10,
  parameter int WS_HI = 330
) (
  input logic          clk,
  input logic          rst,
  input logic          line_pulse,
  input logic          vsync_in,
  input logic [1:0]    field_mode,
  input logic          vpulse_out,
  input logic          rate_50_out,
  input logic          std_valid_out,
  input logic [CW-1:0] cnt
);
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    vpulse_out |=> !vpulse_out);

  a_r2_count_restart: assert property (@(posedge clk) disable iff (rst)
    vpulse_out |-> (cnt == '0));

  a_r3_no_pulse_idle: assert property (@(posedge clk) disable iff (rst)
    (!vsync_in && !line_pulse) |=> !vpulse_out);

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(WS_HI));

  a_r10_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (field_mode == 2'b10) |=> ($stable(rate_50_out) && $stable(std_valid_out)));

  a_r11_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    std_valid_out |=> std_valid_out);
endmodule

bind vert_countdown vc_checker #(.CW(CW), .WS_HI(WS_HI)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .line_pulse   (line_pulse),
  .vsync_in     (vsync_in),
  .field_mode   (field_mode),
  .vpulse_out   (vpulse_out),
  .rate_50_out  (rate_50_out),
  .std_valid_out(std_valid_out),
  .cnt          (cnt_q)
);

// File: tb/test_vert_countdown.sv
module test_vert_countdown;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  typedef struct packed {
    logic [1:0] mode;
    logic       lock;
    logic       srch;
    logic [9:0] sync_at;
    logic [9:0] exp_at;
    logic       exp_v;
    logic       exp_50;
  } vec_t;

  // sync_at 1023 = no sync in that field
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b0, 10'd312,  10'd312, 1'b0, 1'b0}, // R7 R5 search
    '{2'd0, 1'b1, 1'b0, 10'd312,  10'd312, 1'b0, 1'b0}, // R11 run 2
    '{2'd0, 1'b1, 1'b0, 10'd312,  10'd312, 1'b1, 1'b1}, // R11 50 detected
    '{2'd0, 1'b1, 1'b0, 10'd300,  10'd319, 1'b1, 1'b1}, // R3 R4 50 window
    '{2'd0, 1'b1, 1'b0, 10'd262,  10'd319, 1'b1, 1'b1}, // R3
    '{2'd0, 1'b1, 1'b1, 10'd262,  10'd262, 1'b1, 1'b1}, // R6
    '{2'd0, 1'b1, 1'b1, 10'd262,  10'd262, 1'b1, 1'b1}, // R11
    '{2'd0, 1'b1, 1'b1, 10'd262,  10'd262, 1'b1, 1'b0}, // R11 60 detected
    '{2'd0, 1'b1, 1'b0, 10'd312,  10'd269, 1'b1, 1'b0}, // R7 60 window
    '{2'd2, 1'b1, 1'b1, 10'd312,  10'd312, 1'b1, 1'b0}, // R10 frozen
    '{2'd2, 1'b1, 1'b1, 10'd312,  10'd312, 1'b1, 1'b0}, // R10
    '{2'd2, 1'b1, 1'b1, 10'd312,  10'd312, 1'b1, 1'b0}, // R10
    '{2'd3, 1'b0, 1'b0, 10'd262,  10'd319, 1'b1, 1'b0}, // R8 unlocked 50
    '{2'd0, 1'b0, 1'b0, 10'd312,  10'd269, 1'b1, 1'b0}, // R7 unlocked 60
    '{2'd1, 1'b1, 1'b0, 10'd312,  10'd269, 1'b1, 1'b0}, // R9
    '{2'd1, 1'b1, 1'b0, 10'd256,  10'd256, 1'b1, 1'b0}, // R5 low edge
    '{2'd1, 1'b1, 1'b0, 10'd268,  10'd268, 1'b1, 1'b0}, // R5 high edge
    '{2'd1, 1'b1, 1'b0, 10'd255,  10'd269, 1'b1, 1'b0}, // R3 below
    '{2'd0, 1'b1, 1'b0, 10'd1023, 10'd269, 1'b1, 1'b0}, // R4 no sync
    '{2'd0, 1'b1, 1'b1, 10'd1023, 10'd331, 1'b1, 1'b0}, // R4 search end
    '{2'd0, 1'b1, 1'b1, 10'd240,  10'd240, 1'b1, 1'b0}, // R5 search low
    '{2'd0, 1'b1, 1'b1, 10'd330,  10'd330, 1'b1, 1'b0}, // R5 search high
    '{2'd0, 1'b1, 1'b1, 10'd239,  10'd331, 1'b1, 1'b0}  // R3 below search
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_pulse = 1'b0;
  logic       vsync_in = 1'b0;
  logic       line_locked = 1'b1;
  logic [1:0] field_mode = 2'b00;
  logic       search_force = 1'b0;
  logic       vpulse_out;
  logic       rate_50_out;
  logic       std_valid_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  vert_countdown i_vert_countdown (
    .clk(clk), .rst(rst), .line_pulse(line_pulse), .vsync_in(vsync_in),
    .line_locked(line_locked), .field_mode(field_mode),
    .search_force(search_force), .vpulse_out(vpulse_out),
    .rate_50_out(rate_50_out), .std_valid_out(std_valid_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input bit lp, input bit vs, output bit seen);
    line_pulse = lp;
    vsync_in = vs;
    @(negedge clk);
    line_pulse = 1'b0;
    vsync_in = 1'b0;
    seen = vpulse_out;
    @(negedge clk);
  endtask

  task automatic field(input int sync_at, output int got);
    int n = 0;
    bit seen;
    got = -1;
    for (int k = 0; k < 400 && got < 0; k++) begin
      if (n == sync_at) begin
        step(1'b0, 1'b1, seen);
        if (seen) got = n;
      end
      if (got < 0) begin
        step(1'b1, 1'b0, seen);
        n++;
        if (seen) got = n;
      end
    end
  endtask

  initial begin
    int got;
    bit seen;
    bit early;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(vpulse_out == 1'b0, "R1 vpulse", vpulse_out, 0);
    check(std_valid_out == 1'b0, "R1 valid", std_valid_out, 0);
    check(rate_50_out == 1'b0, "R1 rate", rate_50_out, 0);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      field_mode = VECS[i].mode;
      line_locked = VECS[i].lock;
      search_force = VECS[i].srch;
      field(int'(VECS[i].sync_at), got);
      check(got == int'(VECS[i].exp_at), $sformatf("R2/R4 vec%0d pulse line", i),
            got, int'(VECS[i].exp_at));
      check(std_valid_out == VECS[i].exp_v, $sformatf("R11 vec%0d valid", i),
            std_valid_out, VECS[i].exp_v);
      check(rate_50_out == VECS[i].exp_50, $sformatf("R11 vec%0d rate50", i),
            rate_50_out, VECS[i].exp_50);
    end

    // R9: immediate switch to forced 60 when count is past its upper bound
    do_reset();
    field_mode = 2'b00; line_locked = 1'b1; search_force = 1'b0;
    for (int f = 0; f < 3; f++) field(312, got);
    check(std_valid_out && rate_50_out, "R11 fifty before switch", rate_50_out, 1);
    early = 1'b0;
    for (int l = 0; l < 290; l++) begin
      step(1'b1, 1'b0, seen);
      if (seen) early = 1'b1;
    end
    check(!early, "R9 no pulse before switch", early, 0);
    field_mode = 2'b01;
    step(1'b1, 1'b0, seen);
    check(seen, "R9 immediate pulse", seen, 1);

    // R12: sync and window-end line strobe in the same cycle
    do_reset();
    field_mode = 2'b01;
    for (int f = 0; f < 3; f++) begin
      early = 1'b0;
      for (int l = 0; l < 268; l++) begin
        step(1'b1, 1'b0, seen);
        if (seen) early = 1'b1;
      end
      check(!early, "R12 no early pulse", early, 0);
      line_pulse = 1'b1;
      vsync_in = 1'b1;
      @(negedge clk);
      line_pulse = 1'b0;
      vsync_in = 1'b0;
      check(vpulse_out == 1'b1, "R12 coincident pulse", vpulse_out, 1);
      @(negedge clk);
      check(vpulse_out == 1'b0, "R12 single pulse", vpulse_out, 0);
    end
    check(std_valid_out == 1'b1, "R12 counted as sync valid", std_valid_out, 1);
    check(rate_50_out == 1'b0, "R12 counted as sync rate", rate_50_out, 0);
    field(262, got);
    check(got == 262, "R12 count restarted", got, 262);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule